// File: doc/BRIEF.md
# Early Branch Target Checker

This block sits in the decode stage of an out-of-order core. Each cycle it takes a group of up to W instruction records from fetch. Each record carries its sequence number, a few decoded control attributes, the predictor's direction and target, and the target computed by decode. The block looks for two kinds of prediction error. The first is a record that was predicted taken but is not a control instruction. The second is a direct control transfer whose decoded target differs from the predicted one.

When at least one record in the group is wrong, the block picks the oldest wrong record, which is the one in the lowest slot. From that record it builds one redirect packet for fetch. The packet holds the correct next PC, the sequence number of the offending record and a taken flag. At the same time it clears the valid bit of every record in the group that is younger than the offender. Every record whose target was checked leaves with its predicted target replaced by the decoded one. All outputs are registered, so results appear one clock after the inputs.

Top module: `early_branch_checker`

## Requirements
- R1: A valid record with predicted-taken set and is-control clear raises a redirect with rdNotCtrl = 1.
- R2: A target check is done only for a record with is-control and is-direct both set and with either is-unconditional or predicted-taken set. A control record that fails this condition never raises a redirect, whatever its targets.
- R3: A checked valid record whose decoded target differs from its predicted target raises a redirect with rdNotCtrl = 0. In every redirect, rdNextPc equals the offending record's decoded target.
- R4: A redirect drives rdSquash = 1 and rdMispred = 1, and rdSeq equals the offending record's sequence number. In a cycle with no redirect, all redirect outputs are 0.
- R5: rdTaken equals the offending record's branching bit. It is forced to 1 when that record's is-unconditional bit is set.
- R6: outValid for slot i is inValid[i] cleared when a redirect fires and the slot is younger than the offender. Younger means that (seq_i − seq_off) mod 2^SEQ_W, read as a signed SEQ_W-bit value, is greater than 0. The offender and older slots keep their valid bit.
- R7: outPredTarget of each slot equals its decoded target when the R2 check condition holds for that slot. Otherwise it equals its predicted target.
- R8: When several slots are in error in the same cycle, the lowest slot index is the offender.
- R9: Outputs reflect the inputs one clock later. While reset (rstN low) is held, all outputs are 0.
- R10: A slot with inValid = 0 never causes a redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | W | Slot holds a record |
| inSeq | input | W*SEQ_W | Sequence numbers, slot i at [i*SEQ_W +: SEQ_W] |
| inIsCtrl | input | W | Record is a control transfer |
| inIsDirect | input | W | Control target is PC-relative/direct |
| inIsUncond | input | W | Control transfer is unconditional |
| inPredTaken | input | W | Predictor said taken |
| inBranching | input | W | Decoded branching state of the record |
| inPredTarget | input | W*PC_W | Predicted targets |
| inDecTarget | input | W*PC_W | Decoded targets |
| outValid | output | W | Registered valid after squash |
| outPredTarget | output | W*PC_W | Registered, possibly corrected, predicted targets |
| rdSquash | output | 1 | Redirect: squash |
| rdMispred | output | 1 | Redirect: mispredict |
| rdNotCtrl | output | 1 | Redirect caused by a non-control predicted taken |
| rdTaken | output | 1 | Redirect taken flag |
| rdNextPc | output | PC_W | Redirect next PC |
| rdSeq | output | SEQ_W | Sequence number of the offending record |

## Verification
The bench builds the block with W = 4, SEQ_W = 16 and PC_W = 32. Four slots are enough to place two errors in one group with a clean slot between them, so the oldest-wins choice and the younger-slot squash can both be observed. A full 16-bit sequence field lets the bench start a group at 0xFFFE and see the squash decision made correctly across the wrap to 0x0000. Directed groups are followed by a long run of randomized groups, in which predicted and decoded targets agree about half the time.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic fire;     // a redirect is raised this cycle
    logic notCtrl;  // cause: non-control predicted taken
    logic takenBit; // taken flag for the redirect packet
  } ebc_strobe_t;
endpackage

// File: rtl/ebc_ctrl.sv
module ebc_ctrl
  import ebc_pkg::*;
#(
  parameter int W    = 4,
  parameter int PC_W = 32,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]      inValid,
  input  logic [W-1:0]      inIsCtrl,
  input  logic [W-1:0]      inIsDirect,
  input  logic [W-1:0]      inIsUncond,
  input  logic [W-1:0]      inPredTaken,
  input  logic [W-1:0]      inBranching,
  input  logic [W*PC_W-1:0] inPredTarget,
  input  logic [W*PC_W-1:0] inDecTarget,
  output ebc_strobe_t       strobe,
  output logic [IDX_W-1:0]  selIdx,
  output logic [W-1:0]      checkMask
);
  logic [W-1:0] badCtrl;
  logic [W-1:0] badTgt;
  logic [W-1:0] errVec;

  for (genvar g = 0; g < W; g++) begin : gSlot
    assign checkMask[g] = inIsCtrl[g] & inIsDirect[g] & (inIsUncond[g] | inPredTaken[g]);
    assign badCtrl[g]   = inValid[g] & inPredTaken[g] & ~inIsCtrl[g];
    assign badTgt[g]    = inValid[g] & checkMask[g] &
                          (inPredTarget[g*PC_W +: PC_W] != inDecTarget[g*PC_W +: PC_W]);
    assign errVec[g]    = badCtrl[g] | badTgt[g];
  end

  // lowest erroring slot wins
  always_comb begin
    selIdx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (errVec[i]) selIdx = i[IDX_W-1:0];
    end
  end

  always_comb begin
    strobe.fire     = |errVec;
    strobe.notCtrl  = badCtrl[selIdx];
    strobe.takenBit = inIsUncond[selIdx] | inBranching[selIdx];
  end
endmodule

// File: rtl/ebc_datapath.sv
module ebc_datapath
  import ebc_pkg::*;
#(
  parameter int W     = 4,
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  ebc_strobe_t         strobe,
  input  logic [IDX_W-1:0]    selIdx,
  input  logic [W-1:0]        checkMask,
  input  logic [W-1:0]        inValid,
  input  logic [W*SEQ_W-1:0]  inSeq,
  input  logic [W*PC_W-1:0]   inPredTarget,
  input  logic [W*PC_W-1:0]   inDecTarget,
  output logic [W-1:0]        outValid,
  output logic [W*PC_W-1:0]   outPredTarget,
  output logic                rdSquash,
  output logic                rdMispred,
  output logic                rdNotCtrl,
  output logic                rdTaken,
  output logic [PC_W-1:0]     rdNextPc,
  output logic [SEQ_W-1:0]    rdSeq
);
  logic [SEQ_W-1:0]  selSeq;
  logic [PC_W-1:0]   selTarget;
  logic [W-1:0]      younger;
  logic [W-1:0]      nextValid;
  logic [W*PC_W-1:0] nextTarget;

  assign selSeq    = inSeq[int'(selIdx)*SEQ_W +: SEQ_W];
  assign selTarget = inDecTarget[int'(selIdx)*PC_W +: PC_W];

  for (genvar g = 0; g < W; g++) begin : gLane
    logic [SEQ_W-1:0] seqDiff;
    assign seqDiff      = inSeq[g*SEQ_W +: SEQ_W] - selSeq;
    assign younger[g]   = ~seqDiff[SEQ_W-1] & (seqDiff != '0);
    assign nextValid[g] = inValid[g] & ~(strobe.fire & younger[g]);
    assign nextTarget[g*PC_W +: PC_W] = checkMask[g] ? inDecTarget[g*PC_W +: PC_W]
                                                     : inPredTarget[g*PC_W +: PC_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid      <= '0;
      outPredTarget <= '0;
      rdSquash      <= 1'b0;
      rdMispred     <= 1'b0;
      rdNotCtrl     <= 1'b0;
      rdTaken       <= 1'b0;
      rdNextPc      <= '0;
      rdSeq         <= '0;
    end else begin
      outValid      <= nextValid;
      outPredTarget <= nextTarget;
      rdSquash      <= strobe.fire;
      rdMispred     <= strobe.fire;
      rdNotCtrl     <= strobe.fire & strobe.notCtrl;
      rdTaken       <= strobe.fire & strobe.takenBit;
      rdNextPc      <= strobe.fire ? selTarget : '0;
      rdSeq         <= strobe.fire ? selSeq : '0;
    end
  end
endmodule

// File: rtl/early_branch_checker.sv
module early_branch_checker
  import ebc_pkg::*;
#(
  parameter int W     = 4,
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [W-1:0]        inValid,
  input  logic [W*SEQ_W-1:0]  inSeq,
  input  logic [W-1:0]        inIsCtrl,
  input  logic [W-1:0]        inIsDirect,
  input  logic [W-1:0]        inIsUncond,
  input  logic [W-1:0]        inPredTaken,
  input  logic [W-1:0]        inBranching,
  input  logic [W*PC_W-1:0]   inPredTarget,
  input  logic [W*PC_W-1:0]   inDecTarget,
  output logic [W-1:0]        outValid,
  output logic [W*PC_W-1:0]   outPredTarget,
  output logic                rdSquash,
  output logic                rdMispred,
  output logic                rdNotCtrl,
  output logic                rdTaken,
  output logic [PC_W-1:0]     rdNextPc,
  output logic [SEQ_W-1:0]    rdSeq
);
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1;

  ebc_strobe_t      strobe;
  logic [IDX_W-1:0] selIdx;
  logic [W-1:0]     checkMask;

  ebc_ctrl #(.W(W), .PC_W(PC_W)) uCtrl (
    .inValid(inValid), .inIsCtrl(inIsCtrl), .inIsDirect(inIsDirect),
    .inIsUncond(inIsUncond), .inPredTaken(inPredTaken), .inBranching(inBranching),
    .inPredTarget(inPredTarget), .inDecTarget(inDecTarget),
    .strobe(strobe), .selIdx(selIdx), .checkMask(checkMask)
  );

  ebc_datapath #(.W(W), .SEQ_W(SEQ_W), .PC_W(PC_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selIdx(selIdx), .checkMask(checkMask),
    .inValid(inValid), .inSeq(inSeq), .inPredTarget(inPredTarget), .inDecTarget(inDecTarget),
    .outValid(outValid), .outPredTarget(outPredTarget),
    .rdSquash(rdSquash), .rdMispred(rdMispred), .rdNotCtrl(rdNotCtrl),
    .rdTaken(rdTaken), .rdNextPc(rdNextPc), .rdSeq(rdSeq)
  );
endmodule

// File: rtl/ebc_checker.sv
module ebc_checker #(
  parameter int W     = 4,
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [W-1:0]     inValid,
  input logic [W-1:0]     inIsCtrl,
  input logic [W-1:0]     inIsUncond,
  input logic [W-1:0]     inPredTaken,
  input logic [W-1:0]     outValid,
  input logic             rdSquash,
  input logic             rdMispred,
  input logic             rdNotCtrl,
  input logic [PC_W-1:0]  rdNextPc,
  input logic [SEQ_W-1:0] rdSeq
);
  a_r4_flags_paired: assert property (@(posedge clk) disable iff (!rstN)
    rdSquash == rdMispred);

  a_r1_cause_needs_redirect: assert property (@(posedge clk) disable iff (!rstN)
    rdNotCtrl |-> rdSquash);

  a_r10_empty_group_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (inValid == '0) |=> !rdSquash);

  a_r2_unchecked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ((inValid & ~(inIsCtrl & ~inPredTaken & ~inIsUncond)) == '0) |=> !rdSquash);

  a_r6_valid_subset: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((outValid & ~$past(inValid)) == '0));

  a_r4_idle_fields_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rdSquash |-> (rdSeq == '0 && rdNextPc == '0));
endmodule

bind early_branch_checker ebc_checker #(.W(W), .SEQ_W(SEQ_W), .PC_W(PC_W)) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inIsCtrl(inIsCtrl),
  .inIsUncond(inIsUncond), .inPredTaken(inPredTaken), .outValid(outValid),
  .rdSquash(rdSquash), .rdMispred(rdMispred), .rdNotCtrl(rdNotCtrl),
  .rdNextPc(rdNextPc), .rdSeq(rdSeq)
);

// File: tb/tb_early_branch_checker.sv
module tb_early_branch_checker;
  localparam int W = 4;
  localparam int SEQ_W = 16;
  localparam int PC_W = 32;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] inValid = '0, inIsCtrl = '0, inIsDirect = '0, inIsUncond = '0;
  logic [W-1:0] inPredTaken = '0, inBranching = '0;
  logic [W*SEQ_W-1:0] inSeq = '0;
  logic [W*PC_W-1:0] inPredTarget = '0, inDecTarget = '0;
  logic [W-1:0] outValid;
  logic [W*PC_W-1:0] outPredTarget;
  logic rdSquash, rdMispred, rdNotCtrl, rdTaken;
  logic [PC_W-1:0] rdNextPc;
  logic [SEQ_W-1:0] rdSeq;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  logic [W-1:0] eValid;
  logic [W*PC_W-1:0] eTarget;
  logic eSquash, eNotCtrl, eTaken;
  logic [PC_W-1:0] eNextPc;
  logic [SEQ_W-1:0] eSeq;

  always #(CLK_PERIOD/2) clk = ~clk;

  early_branch_checker #(.W(W), .SEQ_W(SEQ_W), .PC_W(PC_W)) dut (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clearAll();
    inValid = '0; inIsCtrl = '0; inIsDirect = '0; inIsUncond = '0;
    inPredTaken = '0; inBranching = '0; inSeq = '0; inPredTarget = '0; inDecTarget = '0;
  endtask

  task automatic setSlot(int i, bit v, int seq, bit c, bit d, bit u, bit pt, bit br,
                         logic [PC_W-1:0] pred, logic [PC_W-1:0] dec);
    inValid[i] = v; inSeq[i*SEQ_W +: SEQ_W] = seq[SEQ_W-1:0];
    inIsCtrl[i] = c; inIsDirect[i] = d; inIsUncond[i] = u;
    inPredTaken[i] = pt; inBranching[i] = br;
    inPredTarget[i*PC_W +: PC_W] = pred; inDecTarget[i*PC_W +: PC_W] = dec;
  endtask

  // Behavioural model of the requirements
  task automatic model();
    int off = -1;
    bit chk;
    logic [SEQ_W-1:0] d;
    for (int i = 0; i < W; i++) begin
      chk = inIsCtrl[i] && inIsDirect[i] && (inIsUncond[i] || inPredTaken[i]);
      eTarget[i*PC_W +: PC_W] = chk ? inDecTarget[i*PC_W +: PC_W] : inPredTarget[i*PC_W +: PC_W];
      if (off < 0 && inValid[i] &&
          ((inPredTaken[i] && !inIsCtrl[i]) ||
           (chk && inPredTarget[i*PC_W +: PC_W] != inDecTarget[i*PC_W +: PC_W])))
        off = i;
    end
    eSquash = (off >= 0);
    eNotCtrl = 0; eTaken = 0; eNextPc = '0; eSeq = '0;
    if (off >= 0) begin
      eNotCtrl = inPredTaken[off] && !inIsCtrl[off];
      eTaken = inIsUncond[off] ? 1'b1 : inBranching[off];
      eNextPc = inDecTarget[off*PC_W +: PC_W];
      eSeq = inSeq[off*SEQ_W +: SEQ_W];
    end
    for (int i = 0; i < W; i++) begin
      eValid[i] = inValid[i];
      if (off >= 0) begin
        d = inSeq[i*SEQ_W +: SEQ_W] - eSeq;
        if ($signed(d) > 0) eValid[i] = 1'b0;
      end
    end
  endtask

  task automatic cycle();
    model();
    @(posedge clk);
    @(negedge clk);
    check("R4 rdSquash", 64'(rdSquash), 64'(eSquash));
    check("R4 rdMispred", 64'(rdMispred), 64'(eSquash));
    check("R4 rdSeq", 64'(rdSeq), 64'(eSeq));
    check("R1 rdNotCtrl", 64'(rdNotCtrl), 64'(eNotCtrl));
    check("R5 rdTaken", 64'(rdTaken), 64'(eTaken));
    check("R3 rdNextPc", 64'(rdNextPc), 64'(eNextPc));
    check("R6 outValid", 64'(outValid), 64'(eValid));
    for (int i = 0; i < W; i++)
      check("R7 outPredTarget", 64'(outPredTarget[i*PC_W +: PC_W]), 64'(eTarget[i*PC_W +: PC_W]));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nErrors++; nChecks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    // R9: reset holds outputs at zero even with live inputs
    setSlot(0, 1, 5, 0, 0, 0, 1, 0, 32'h10, 32'h20);
    repeat (3) @(negedge clk);
    check("R9 reset squash", 64'(rdSquash), 64'd0);
    check("R9 reset valid", 64'(outValid), 64'd0);
    check("R9 reset nextpc", 64'(rdNextPc), 64'd0);
    clearAll();
    rstN = 1'b1;
    @(negedge clk);

    // R10: empty group, and an invalid slot that would be wrong
    cycle();
    setSlot(1, 0, 7, 0, 0, 0, 1, 1, 32'h100, 32'h200);
    cycle();

    // R1: non-control predicted taken in slot 1
    clearAll();
    for (int i = 0; i < W; i++) setSlot(i, 1, 40 + i, 0, 0, 0, 0, 0, 32'h1000 + 32'(i*4), 32'h1000 + 32'(i*4));
    setSlot(1, 1, 41, 0, 0, 0, 1, 0, 32'h3000, 32'h1008);
    cycle();

    // R3/R5: unconditional direct mismatch, branching=0 forced taken
    clearAll();
    for (int i = 0; i < W; i++) setSlot(i, 1, 100 + i, 0, 0, 0, 0, 0, 32'h0, 32'h0);
    setSlot(2, 1, 102, 1, 1, 1, 0, 0, 32'h4000, 32'h4440);
    cycle();

    // R5: conditional predicted taken, branching=1
    setSlot(2, 1, 102, 1, 1, 0, 1, 1, 32'h4000, 32'h4880);
    cycle();

    // R2: conditional not predicted taken, and indirect taken, with mismatches
    clearAll();
    setSlot(0, 1, 200, 1, 1, 0, 0, 0, 32'h1, 32'h2);
    setSlot(1, 1, 201, 1, 0, 1, 1, 1, 32'h3, 32'h4);
    setSlot(2, 1, 202, 1, 0, 0, 1, 1, 32'h5, 32'h6);
    cycle();

    // R7: matching checked record passes, target kept
    setSlot(3, 1, 203, 1, 1, 0, 1, 1, 32'h77, 32'h77);
    cycle();

    // R8: errors in slots 1 and 3; slot 1 wins
    clearAll();
    for (int i = 0; i < W; i++) setSlot(i, 1, 300 + i, 0, 0, 0, 0, 0, 32'h0, 32'h0);
    setSlot(1, 1, 301, 1, 1, 1, 1, 1, 32'hA0, 32'hB0);
    setSlot(3, 1, 303, 0, 0, 0, 1, 0, 32'hC0, 32'hD0);
    cycle();

    // R6: sequence wrap 0xFFFE..0x0001, error in slot 1 (0xFFFF)
    clearAll();
    for (int i = 0; i < W; i++) setSlot(i, 1, (16'hFFFE + i) & 16'hFFFF, 0, 0, 0, 0, 0, 32'h0, 32'h0);
    setSlot(1, 1, 16'hFFFF, 1, 1, 1, 1, 1, 32'h10, 32'h14);
    cycle();

    // Randomized groups covering all requirements
    for (int n = 0; n < 400; n++) begin
      int base = $urandom & 16'hFFFF;
      clearAll();
      for (int i = 0; i < W; i++) begin
        logic [PC_W-1:0] dec = $urandom;
        logic [PC_W-1:0] pred = ($urandom % 2) ? dec : (dec ^ 32'h4);
        bit pt = ($urandom % 4) == 0;
        setSlot(i, ($urandom % 8) != 0, (base + i) & 16'hFFFF, ($urandom % 2) == 1,
                ($urandom % 2) == 1, ($urandom % 2) == 1, pt, ($urandom % 2) == 1, pred, dec);
      end
      cycle();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule